// File: doc/BRIEF.md
# Pin Edge and Wake-Up Interrupt Detector

This block turns external pin activity into interrupt request strobes. It serves three request lines. Line 0 is an edge-triggered external interrupt. Line 1 is an edge-triggered external interrupt that can also act as a key wake-up or be muted. The third line is a counter-pin interrupt that can be sourced from either of two counter pins. Every pin passes through a two-stage synchroniser. An edge is found by comparing the current synchronised value with the value from the previous clock. A software-written mode byte sets the active edge of each line, the counter-pin source and the wake-up mode.

Line 1 depends on the power-down status input and the wake select bit (bit 5) together. If the bit is clear, line 1 is an ordinary edge interrupt. If the bit is set while the device is powered down, line 1 raises a request when any input-mode pin of an 8-bit key port goes low. If the bit is set while the device is running, line 1 is silent. Each request is a single-cycle strobe meant for a separate request-latching register.

Top module: `pinirq_top`

## Requirements
- R1: While reset is asserted, and for three clocks after it is released, all three request outputs are 0.
- R2: Mode bit 0 selects the active edge of intPin0: 0 selects falling and 1 selects rising. An active edge produces one reqInt0 pulse. The pulse is high in the clock period that starts at the third rising clock edge after the pin changes. The inactive edge produces nothing.
- R3: When mode bit 5 is 0, intPin1 behaves like R2 using mode bit 1, whatever the state of powerDown.
- R4: Mode bit 4 picks the counter-pin source: 0 selects cntPin0 and 1 selects cntPin1. Mode bit 2 sets the active edge, encoded as in R2. reqCnt pulses with the R2 latency. The pin that is not selected has no effect.
- R5: When powerDown is 1 and mode bit 5 is 1, reqInt1 pulses once when the state becomes "any enabled key pin low". It stays quiet until every enabled key pin is high again. Entering this mode while a key pin is already low produces one pulse.
- R6: A key pin whose keyIsInput bit is 0 never contributes to the wake-up request.
- R7: When mode bit 5 is 1 and powerDown is 0, reqInt1 stays 0 whatever intPin1 and the key port do.
- R8: In wake-up mode, edges on intPin1 produce no reqInt1.
- R9: Changing a polarity bit while the pins are steady produces no strobe.
- R10: Changing the counter source bit while the two counter pins differ produces no strobe.
- R11: Mode bits 3, 6 and 7 have no effect on any output.
- R12: Line 0, line 1 and the counter line are independent. Events that fall in the same cycle each produce their own pulse in the same output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intPin0 | input | 1 | External interrupt pin, line 0 |
| intPin1 | input | 1 | External interrupt pin, line 1 |
| cntPin0 | input | 1 | Counter pin 0 |
| cntPin1 | input | 1 | Counter pin 1 |
| keyPort | input | 8 | Key port levels sensed for wake-up |
| keyIsInput | input | 8 | Per-pin input-mode flags for the key port |
| powerDown | input | 1 | Device is in a power-down state |
| modeSel | input | 8 | Mode byte: bit0/1/2 polarities, bit4 counter source, bit5 wake select |
| reqInt0 | output | 1 | Request strobe, line 0 |
| reqInt1 | output | 1 | Request strobe, line 1 (edge or wake-up) |
| reqCnt | output | 1 | Request strobe, counter pin line |

## Verification
A line 0 edge and a key wake-up on line 1 can land in the same output cycle, because they travel identical synchroniser paths. The bench drives a falling intPin0 and a low key pin on the same negative clock edge while the block is in wake-up mode. It expects exactly one pulse on each line, both in the third cycle. The rest of the bench sweeps every combination of polarity, edge direction, counter source, toggled counter pin and key pin index. It computes the expected pulse count and cycle from the requirement rules.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int KEY_W      = 8;
  localparam int SYNC_DEPTH = 2;
  localparam int POL0_BIT   = 0;
  localparam int POL1_BIT   = 1;
  localparam int POLC_BIT   = 2;
  localparam int CSEL_BIT   = 4;
  localparam int WAKE_BIT   = 5;

  typedef struct packed {
    logic armed;
    logic pol0;
    logic pol1;
    logic polCnt;
    logic cntSel;
    logic keyMode;
    logic line1Mute;
  } ctlStrobes_t;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[0] <= '1;
          else       stage[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= '1;
          else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pinirq_control.sv
module pinirq_control
  import pinirq_pkg::*;
#(
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerDown,
  input  logic [7:0]  modeSel,
  output ctlStrobes_t ctl
);
  localparam int ARM_CYC = STAGES + 1;
  localparam int CNT_W   = $clog2(ARM_CYC + 1);

  logic [CNT_W-1:0] armCnt;
  logic             armed;

  // Edge logic needs the synchroniser and history register filled first.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                           armCnt <= '0;
    else if (armCnt != CNT_W'(ARM_CYC))  armCnt <= armCnt + 1'b1;

  assign armed = (armCnt == CNT_W'(ARM_CYC));

  always_comb begin
    ctl.armed     = armed;
    ctl.pol0      = modeSel[POL0_BIT];
    ctl.pol1      = modeSel[POL1_BIT];
    ctl.polCnt    = modeSel[POLC_BIT];
    ctl.cntSel    = modeSel[CSEL_BIT];
    ctl.keyMode   = powerDown &  modeSel[WAKE_BIT];
    ctl.line1Mute = ~powerDown & modeSel[WAKE_BIT];
  end
endmodule

// File: rtl/pinirq_datapath.sv
module pinirq_datapath
  import pinirq_pkg::*;
#(
  parameter int KW     = KEY_W,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          intPin0,
  input  logic          intPin1,
  input  logic          cntPin0,
  input  logic          cntPin1,
  input  logic [KW-1:0] keyPort,
  input  logic [KW-1:0] keyIsInput,
  input  ctlStrobes_t   ctl,
  output logic          reqInt0,
  output logic          reqInt1,
  output logic          reqCnt
);
  localparam int N      = KW + 4;
  localparam int I_INT0 = 0;
  localparam int I_INT1 = 1;
  localparam int I_CNT0 = 2;
  localparam int I_CNT1 = 3;
  localparam int I_KEY  = 4;

  logic [N-1:0] rawPins, syncQ, prevQ, riseV, fallV;
  logic         hit0, hit1, cntRise, cntFall, cntHit;
  logic         keyLow, keyPrev, keyHit, line1;

  assign rawPins = {keyPort, cntPin1, cntPin0, intPin1, intPin0};

  pinirq_sync #(.W(N), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (rawPins),
    .q   (syncQ)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= '1;
    else       prevQ <= syncQ;

  // Per-pin edges before any muxing, so select or polarity changes cannot fake one.
  assign riseV = syncQ & ~prevQ;
  assign fallV = ~syncQ & prevQ;

  assign hit0    = ctl.pol0 ? riseV[I_INT0] : fallV[I_INT0];
  assign hit1    = ctl.pol1 ? riseV[I_INT1] : fallV[I_INT1];
  assign cntRise = ctl.cntSel ? riseV[I_CNT1] : riseV[I_CNT0];
  assign cntFall = ctl.cntSel ? fallV[I_CNT1] : fallV[I_CNT0];
  assign cntHit  = ctl.polCnt ? cntRise : cntFall;

  assign keyLow = |(~syncQ[N-1:I_KEY] & keyIsInput);
  assign keyHit = keyLow & ~keyPrev;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) keyPrev <= 1'b0;
    else       keyPrev <= ctl.keyMode & keyLow;

  always_comb begin
    if (ctl.keyMode)        line1 = keyHit;
    else if (ctl.line1Mute) line1 = 1'b0;
    else                    line1 = hit1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      reqInt0 <= 1'b0;
      reqInt1 <= 1'b0;
      reqCnt  <= 1'b0;
    end else begin
      reqInt0 <= ctl.armed & hit0;
      reqInt1 <= ctl.armed & line1;
      reqCnt  <= ctl.armed & cntHit;
    end
endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intPin0,
  input  logic       intPin1,
  input  logic       cntPin0,
  input  logic       cntPin1,
  input  logic [7:0] keyPort,
  input  logic [7:0] keyIsInput,
  input  logic       powerDown,
  input  logic [7:0] modeSel,
  output logic       reqInt0,
  output logic       reqInt1,
  output logic       reqCnt
);
  ctlStrobes_t ctl;

  pinirq_control #(.STAGES(SYNC_DEPTH)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .powerDown(powerDown),
    .modeSel  (modeSel),
    .ctl      (ctl)
  );

  pinirq_datapath #(.KW(KEY_W), .STAGES(SYNC_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .intPin0   (intPin0),
    .intPin1   (intPin1),
    .cntPin0   (cntPin0),
    .cntPin1   (cntPin1),
    .keyPort   (keyPort),
    .keyIsInput(keyIsInput),
    .ctl       (ctl),
    .reqInt0   (reqInt0),
    .reqInt1   (reqInt1),
    .reqCnt    (reqCnt)
  );
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       intPin0,
  input logic       cntPin0,
  input logic       cntPin1,
  input logic       powerDown,
  input logic [7:0] modeSel,
  input logic       reqInt0,
  input logic       reqInt1,
  input logic       reqCnt
);
  logic wakeMode;
  assign wakeMode = powerDown && modeSel[5];

  // R1
  always @(negedge clk)
    if (!rstN) a_r1_reset_quiet: assert (!reqInt0 && !reqInt1 && !reqCnt);

  // R2: a strobe needs a real pin change three cycles back
  a_r2_int0_change: assert property (@(posedge clk) disable iff (!rstN)
    reqInt0 |-> ($past(intPin0, 3) != $past(intPin0, 4)));

  // R2: and that change must be in the selected direction
  a_r2_int0_polarity: assert property (@(posedge clk) disable iff (!rstN)
    reqInt0 |-> ($past(intPin0, 3) == $past(modeSel[0], 1)));

  // R4
  a_r4_cnt_source: assert property (@(posedge clk) disable iff (!rstN)
    reqCnt |-> ($past(modeSel[4], 1)
                ? ($past(cntPin1, 3) != $past(cntPin1, 4))
                : ($past(cntPin0, 3) != $past(cntPin0, 4))));

  // R7
  a_r7_line1_muted: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeSel[5] && !powerDown) |-> !reqInt1);

  // R5
  a_r5_wake_once: assert property (@(posedge clk) disable iff (!rstN)
    (reqInt1 && $past(wakeMode) && wakeMode) |=> !reqInt1);
endmodule

bind pinirq_top pinirq_checker u_chk (.*);

// File: tb/tb_pinirq_top.sv
`timescale 1ns/1ps
module tb_pinirq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intPin0 = 1'b1, intPin1 = 1'b1, cntPin0 = 1'b1, cntPin1 = 1'b1;
  logic [7:0] keyPort = 8'hFF, keyIsInput = 8'hFF, modeSel = 8'h00;
  logic       powerDown = 1'b0;
  logic       reqInt0, reqInt1, reqCnt;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pinirq_top dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // counts pulses over n cycles; first* is the sample index of the first pulse
  task automatic watch(input int n, output int c0, output int c1, output int cc,
                       output int f0, output int f1, output int fc);
    c0 = 0; c1 = 0; cc = 0; f0 = -1; f1 = -1; fc = -1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (reqInt0) begin c0++; if (f0 < 0) f0 = i; end
      if (reqInt1) begin c1++; if (f1 < 0) f1 = i; end
      if (reqCnt)  begin cc++; if (fc < 0) fc = i; end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  initial begin
    int c0, c1, cc, f0, f1, fc, exp;
    // R1: reset and arming window
    intPin0 = 1'b0;
    settle(3);
    check(!reqInt0 && !reqInt1 && !reqCnt, "R1 in reset", reqInt0 + reqInt1 + reqCnt, 0);
    @(negedge clk) rstN = 1'b1;
    watch(3, c0, c1, cc, f0, f1, fc);
    check(c0 + c1 + cc == 0, "R1 arming", c0 + c1 + cc, 0);
    intPin0 = 1'b1;
    settle(6);

    // R2: line 0 polarity and latency sweep
    for (int pol = 0; pol < 2; pol++)
      for (int nv = 0; nv < 2; nv++) begin
        modeSel = 8'(pol); intPin0 = ~1'(nv); settle(6);
        intPin0 = 1'(nv);
        watch(6, c0, c1, cc, f0, f1, fc);
        exp = (nv == pol) ? 1 : 0;
        check(c0 == exp, "R2 count", c0, exp);
        if (exp == 1) check(f0 == 3, "R2 latency", f0, 3);
        check(c1 + cc == 0, "R12 others quiet", c1 + cc, 0);
      end

    // R3: line 1 with wake bit clear, both power states
    for (int pd = 0; pd < 2; pd++)
      for (int pol = 0; pol < 2; pol++)
        for (int nv = 0; nv < 2; nv++) begin
          powerDown = 1'(pd); modeSel = 8'(pol << 1); intPin1 = ~1'(nv); settle(6);
          intPin1 = 1'(nv);
          watch(6, c0, c1, cc, f0, f1, fc);
          exp = (nv == pol) ? 1 : 0;
          check(c1 == exp, "R3 count", c1, exp);
          if (exp == 1) check(f1 == 3, "R3 latency", f1, 3);
        end
    powerDown = 1'b0;

    // R4: counter source, polarity, which pin moves
    for (int sel = 0; sel < 2; sel++)
      for (int pol = 0; pol < 2; pol++)
        for (int pin = 0; pin < 2; pin++)
          for (int nv = 0; nv < 2; nv++) begin
            modeSel = 8'((sel << 4) | (pol << 2));
            cntPin0 = 1'b1; cntPin1 = 1'b1;
            if (pin == 0) cntPin0 = ~1'(nv); else cntPin1 = ~1'(nv);
            settle(6);
            if (pin == 0) cntPin0 = 1'(nv); else cntPin1 = 1'(nv);
            watch(6, c0, c1, cc, f0, f1, fc);
            exp = (pin == sel && nv == pol) ? 1 : 0;
            check(cc == exp, "R4 count", cc, exp);
            if (exp == 1) check(fc == 3, "R4 latency", fc, 3);
          end

    // R10: flip source while pins differ
    cntPin0 = 1'b0; cntPin1 = 1'b1; modeSel = 8'h00; settle(6);
    for (int k = 0; k < 4; k++) begin
      modeSel = modeSel ^ 8'h10;
      watch(4, c0, c1, cc, f0, f1, fc);
      check(cc == 0, "R10 source flip", cc, 0);
    end
    cntPin0 = 1'b1;

    // R9: polarity flips with steady pins at both levels
    for (int lvl = 0; lvl < 2; lvl++) begin
      intPin0 = 1'(lvl); intPin1 = 1'(lvl); cntPin0 = 1'(lvl); modeSel = 8'h00; settle(6);
      for (int b = 0; b < 3; b++) begin
        modeSel = modeSel ^ 8'(1 << b);
        watch(4, c0, c1, cc, f0, f1, fc);
        check(c0 + c1 + cc == 0, "R9 polarity flip", c0 + c1 + cc, 0);
      end
    end
    intPin0 = 1'b1; intPin1 = 1'b1; cntPin0 = 1'b1; modeSel = 8'h00; settle(6);

    // R11: reserved bits toggled, then still-normal edge behaviour
    modeSel = 8'hC8;
    watch(4, c0, c1, cc, f0, f1, fc);
    check(c0 + c1 + cc == 0, "R11 reserved toggle", c0 + c1 + cc, 0);
    intPin0 = 1'b0;
    watch(6, c0, c1, cc, f0, f1, fc);
    check(c0 == 1 && f0 == 3, "R11 falling still active", c0, 1);
    intPin0 = 1'b1; modeSel = 8'h00; settle(6);

    // R5: wake-up per key pin
    powerDown = 1'b1; modeSel = 8'h20; keyIsInput = 8'hFF; keyPort = 8'hFF; settle(6);
    for (int i = 0; i < 8; i++) begin
      keyPort = ~(8'(1) << i);
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 1 && f1 == 3, "R5 key low", c1, 1);
      keyPort = keyPort & ~(8'(1) << ((i + 3) % 8));
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 0, "R5 no repeat", c1, 0);
      keyPort = 8'hFF;
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 0, "R5 release quiet", c1, 0);
    end

    // R6: masked pins ignored
    for (int i = 0; i < 8; i++) begin
      keyIsInput = ~(8'(1) << i); keyPort = ~(8'(1) << i);
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 0, "R6 masked pin", c1, 0);
      keyPort = 8'hFF; settle(4);
    end
    keyIsInput = 8'hFF;

    // R8: line 1 edges ignored in wake-up mode
    for (int pol = 0; pol < 2; pol++) begin
      modeSel = 8'h20 | 8'(pol << 1); settle(4);
      intPin1 = 1'b0;
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 0, "R8 fall ignored", c1, 0);
      intPin1 = 1'b1;
      watch(6, c0, c1, cc, f0, f1, fc);
      check(c1 == 0, "R8 rise ignored", c1, 0);
    end
    modeSel = 8'h20; settle(4);

    // R12: line 0 edge and wake-up in the same cycle
    intPin0 = 1'b0; keyPort = 8'hEF;
    watch(6, c0, c1, cc, f0, f1, fc);
    check(c0 == 1 && f0 == 3, "R12 line0 together", f0, 3);
    check(c1 == 1 && f1 == 3, "R12 wake together", f1, 3);
    intPin0 = 1'b1; keyPort = 8'hFF; settle(6);

    // R7: wake bit set while running
    powerDown = 1'b0; settle(4);
    intPin1 = 1'b0; keyPort = 8'h00;
    watch(6, c0, c1, cc, f0, f1, fc);
    check(c1 == 0, "R7 muted fall", c1, 0);
    intPin1 = 1'b1;
    watch(6, c0, c1, cc, f0, f1, fc);
    check(c1 == 0, "R7 muted rise", c1, 0);

    // R5: entering wake-up with a key already low gives one pulse
    keyPort = 8'hFE; settle(4);
    powerDown = 1'b1;
    watch(8, c0, c1, cc, f0, f1, fc);
    check(c1 == 1, "R5 enter while low", c1, 1);

    finishRun();
  end
endmodule